// File: doc/BRIEF.md
# Protected Clock Control Unit

This block decides which of three clock sources drives the system. The sources are a fast oscillator, a PLL output and a 32.768 kHz slow oscillator. Each source reaches the block as a one-cycle tick on a single fast reference clock. The block divides the chosen source to form the system clock and divides that result again to form the core clock. Both derived clocks leave the block as clock-enable strobes. The system strobe also feeds one gated enable per peripheral group.

Software reaches the unit over a simple register bus with a 4-bit address and 8-bit data. The control registers at offsets 0x0 to 0xD are locked against writes. A key byte written to a separate register at offset 0xE unlocks them. Software re-locks them by writing any other byte there.

A mode register can stop the core strobe (halt) or stop everything (sleep). A wakeup input brings clocking back.

Top module: `clock_control_unit`

## Requirements
- R1: After reset the fast source is selected, both divide ratios are 1, every peripheral gate is on, the unit is locked and neither halt nor sleep is active. Reads of offsets 0x0 to 0x4 return 0, 0, 0, all-ones in the gate bits, and 0.
- R2: The source field at offset 0x0, bits [1:0], selects the fast source with 0, the PLL with 1, and the slow oscillator with 2 or 3. `sysEn` pulses are derived only from ticks of the selected source.
- R3: While the unit is locked, writes to offsets 0x0 through 0xD are discarded. A read returns the current contents at any time.
- R4: A write of 0x96 to offset 0xE unlocks the unit, and a write of any other byte locks it. A read of offset 0xE returns the lock state in bit 0, with 1 meaning unlocked.
- R5: Offset 0x1, bits [4:0], holds the system ratio minus one. With ratio N (1 to 32), `sysEn` pulses exactly once every N ticks of the selected source. With ratio 1 it follows every tick.
- R6: Offset 0x2, bits [2:0], holds the core ratio minus one. With ratio M (1 to 8), `coreEn` pulses once every M `sysEn` pulses and is never high without `sysEn`.
- R7: A new source or ratio takes effect only at the divider's next output pulse. The period already under way finishes at the old setting.
- R8: Bit g of the gate register at offset 0x3 makes `periphEn[g]` follow `sysEn` when it is 1 and hold `periphEn[g]` at 0 when it is 0.
- R9: Writing bit 0 = 1 to the mode register at offset 0x4 enters halt. In halt, `halted` is 1, `coreEn` is 0, and `sysEn` keeps pulsing.
- R10: Writing bit 1 = 1 to offset 0x4 enters sleep. In sleep, `sleeping` is 1 and `sysEn`, `coreEn` and `periphEn` are all 0. A read of offset 0x4 returns {sleeping, halted} in bits [1:0].
- R11: When `wakeup` is high at a clock edge, it clears halt and sleep at that edge. It takes priority over a mode write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register offset for reads and writes |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| fastTick | input | 1 | Fast oscillator tick |
| pllTick | input | 1 | PLL output tick |
| slowTick | input | 1 | Slow oscillator tick |
| wakeup | input | 1 | Leaves halt and sleep |
| sysEn | output | 1 | System clock enable |
| coreEn | output | 1 | Core clock enable |
| periphEn | output | NUM_GROUPS | Gated enable per peripheral group |
| halted | output | 1 | Halt is active |
| sleeping | output | 1 | Sleep is active |

## Verification
A wrong divider count shows up at the ports as a pulse gap that is off on the very next `sysEn` or `coreEn` pulse. Every pulse interval is therefore compared against the source period times the ratio. A broken lock shows up within one cycle in the readback of the register that was written, and within one divider period in the pulse spacing. A stuck halt or sleep flag appears the cycle after `wakeup` as a missing `coreEn` or `sysEn`. A missed boundary rule shows up as a short or long first gap after a ratio change.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int SYS_DIV_W  = 5;
  localparam int CORE_DIV_W = 3;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;

  localparam logic [ADDR_W-1:0] OFS_SRC     = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SYSDIV  = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_COREDIV = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_GATE    = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_MODE    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_LASTPROT = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_KEY     = 4'hE;
  localparam logic [DATA_W-1:0] UNLOCK_KEY  = 8'h96;

  typedef enum logic [1:0] {
    SRC_FAST  = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_SLOW2 = 2'd3
  } src_e;

  typedef struct packed {
    src_e                  srcSel;
    logic [SYS_DIV_W-1:0]  sysDivM1;
    logic [CORE_DIV_W-1:0] coreDivM1;
    logic                  halted;
    logic                  sleeping;
  } ctrl_t;
endpackage

// File: rtl/ccu_tick_div.sv
module ccu_tick_div #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickIn,
  input  logic         run,
  input  logic [W-1:0] pendDivM1,
  output logic         boundary,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W-1:0] activeM1;
  logic [W-1:0] effM1;

  // A new ratio is adopted only while the count rests at zero.
  assign boundary = (cnt == '0);
  assign effM1    = boundary ? pendDivM1 : activeM1;
  assign pulse    = tickIn && run && boundary;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      activeM1 <= '0;
    end else begin
      if (boundary) activeM1 <= pendDivM1;
      if (tickIn && run) cnt <= (cnt == effM1) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccu_regs.sv
module ccu_regs
  import ccu_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic                  wakeup,
  output logic [DATA_W-1:0]     busRdData,
  output ctrl_t                 ctrl,
  output logic [NUM_GROUPS-1:0] gate,
  output logic                  unlocked
);
  logic inProtRange;
  logic wrOk;

  assign inProtRange = (busAddr <= OFS_LASTPROT);
  assign wrOk        = busWrEn && unlocked && inProtRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl.srcSel    <= SRC_FAST;
      ctrl.sysDivM1  <= '0;
      ctrl.coreDivM1 <= '0;
      ctrl.halted    <= 1'b0;
      ctrl.sleeping  <= 1'b0;
      gate           <= '1;
      unlocked       <= 1'b0;
    end else begin
      if (busWrEn && busAddr == OFS_KEY) unlocked <= (busWrData == UNLOCK_KEY);
      if (wrOk) begin
        case (busAddr)
          OFS_SRC:     ctrl.srcSel    <= src_e'(busWrData[1:0]);
          OFS_SYSDIV:  ctrl.sysDivM1  <= busWrData[SYS_DIV_W-1:0];
          OFS_COREDIV: ctrl.coreDivM1 <= busWrData[CORE_DIV_W-1:0];
          OFS_GATE:    gate           <= busWrData[NUM_GROUPS-1:0];
          default: ;
        endcase
      end
      if (wakeup) begin
        ctrl.halted   <= 1'b0;
        ctrl.sleeping <= 1'b0;
      end else if (wrOk && busAddr == OFS_MODE) begin
        ctrl.halted   <= ctrl.halted | busWrData[0];
        ctrl.sleeping <= ctrl.sleeping | busWrData[1];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_SRC:     busRdData = DATA_W'(ctrl.srcSel);
      OFS_SYSDIV:  busRdData = DATA_W'(ctrl.sysDivM1);
      OFS_COREDIV: busRdData = DATA_W'(ctrl.coreDivM1);
      OFS_GATE:    busRdData = DATA_W'(gate);
      OFS_MODE:    busRdData = DATA_W'({ctrl.sleeping, ctrl.halted});
      OFS_KEY:     busRdData = DATA_W'(unlocked);
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/ccu_divpath.sv
module ccu_divpath
  import ccu_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fastTick,
  input  logic                  pllTick,
  input  logic                  slowTick,
  input  ctrl_t                 ctrl,
  input  logic [NUM_GROUPS-1:0] gate,
  output logic                  sysEn,
  output logic                  coreEn,
  output logic [NUM_GROUPS-1:0] periphEn
);
  src_e activeSel;
  src_e effSel;
  logic sysBoundary;
  logic coreBoundary;
  logic srcTick;

  assign effSel = sysBoundary ? ctrl.srcSel : activeSel;

  always_comb begin
    case (effSel)
      SRC_FAST: srcTick = fastTick;
      SRC_PLL:  srcTick = pllTick;
      default:  srcTick = slowTick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            activeSel <= SRC_FAST;
    else if (sysBoundary) activeSel <= ctrl.srcSel;
  end

  ccu_tick_div #(.W(SYS_DIV_W)) u_sysDiv (
    .clk(clk), .rstN(rstN), .tickIn(srcTick), .run(!ctrl.sleeping),
    .pendDivM1(ctrl.sysDivM1), .boundary(sysBoundary), .pulse(sysEn)
  );

  ccu_tick_div #(.W(CORE_DIV_W)) u_coreDiv (
    .clk(clk), .rstN(rstN), .tickIn(sysEn), .run(!ctrl.halted),
    .pendDivM1(ctrl.coreDivM1), .boundary(coreBoundary), .pulse(coreEn)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gate
    assign periphEn[g] = sysEn && gate[g];
  end
endmodule

// File: rtl/clock_control_unit.sv
module clock_control_unit
  import ccu_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [3:0]            busAddr,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  input  logic                  fastTick,
  input  logic                  pllTick,
  input  logic                  slowTick,
  input  logic                  wakeup,
  output logic                  sysEn,
  output logic                  coreEn,
  output logic [NUM_GROUPS-1:0] periphEn,
  output logic                  halted,
  output logic                  sleeping
);
  ctrl_t                 ctrl;
  logic [NUM_GROUPS-1:0] gate;
  logic                  unlocked;

  ccu_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .wakeup(wakeup), .busRdData(busRdData),
    .ctrl(ctrl), .gate(gate), .unlocked(unlocked)
  );

  ccu_divpath #(.NUM_GROUPS(NUM_GROUPS)) u_path (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .pllTick(pllTick),
    .slowTick(slowTick), .ctrl(ctrl), .gate(gate), .sysEn(sysEn),
    .coreEn(coreEn), .periphEn(periphEn)
  );

  assign halted   = ctrl.halted;
  assign sleeping = ctrl.sleeping;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker
  import ccu_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [3:0]            busAddr,
  input logic [7:0]            busWrData,
  input logic                  wakeup,
  input logic                  sysEn,
  input logic                  coreEn,
  input logic [NUM_GROUPS-1:0] periphEn,
  input logic                  halted,
  input logic                  sleeping,
  input ctrl_t                 ctrl,
  input logic [NUM_GROUPS-1:0] gate,
  input logic                  unlocked
);
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !unlocked && busAddr <= OFS_LASTPROT && !wakeup) |=>
      ($stable(ctrl.srcSel) && $stable(ctrl.sysDivM1) && $stable(ctrl.coreDivM1)
       && $stable(gate) && $stable(ctrl.halted) && $stable(ctrl.sleeping)));

  a_r4_key_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_KEY && busWrData == UNLOCK_KEY) |=> unlocked);

  a_r4_other_locks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_KEY && busWrData != UNLOCK_KEY) |=> !unlocked);

  a_r6_core_within_sys: assert property (@(posedge clk) disable iff (!rstN)
    coreEn |-> sysEn);

  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    (periphEn & ~gate) == '0);

  a_r9_halt_core: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !coreEn);

  a_r10_sleep_all: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> (!sysEn && !coreEn && periphEn == '0));

  a_r11_wakeup: assert property (@(posedge clk) disable iff (!rstN)
    wakeup |=> (!halted && !sleeping));
endmodule

bind clock_control_unit ccu_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .wakeup(wakeup), .sysEn(sysEn), .coreEn(coreEn),
  .periphEn(periphEn), .halted(halted), .sleeping(sleeping),
  .ctrl(ctrl), .gate(gate), .unlocked(unlocked)
);

// File: tb/clock_control_unit_bench.sv
module clock_control_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int NVEC = 6;
  // sel, sysRatio, coreRatio
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{0, 1, 1}, '{1, 3, 2}, '{2, 2, 3}, '{3, 1, 4}, '{1, 5, 1}, '{0, 7, 8}};

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, wakeup = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0, busRdData;
  logic fastTick, pllTick, slowTick, sysEn, coreEn, halted, sleeping;
  logic [NG-1:0] periphEn;
  int tickCnt = 0, nChecks = 0, nFails = 0, lastCore = 1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin @(negedge clk); tickCnt++; end
  assign fastTick = 1'b1;
  assign pllTick  = (tickCnt % 2) == 0;
  assign slowTick = (tickCnt % 7) == 0;

  clock_control_unit #(.NUM_GROUPS(NG)) u_clock_control_unit (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .fastTick(fastTick),
    .pllTick(pllTick), .slowTick(slowTick), .wakeup(wakeup), .sysEn(sysEn),
    .coreEn(coreEn), .periphEn(periphEn), .halted(halted), .sleeping(sleeping));

  function automatic int srcPer(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : 7;
  endfunction
  function automatic int cyc();
    return int'($time / CLK_PERIOD);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int d);
    busAddr = a; #1; d = int'(busRdData);
  endtask

  task automatic cfg(int sel, int sr, int cr);
    wr(4'h0, 8'(sel)); wr(4'h1, 8'(sr - 1)); wr(4'h2, 8'(cr - 1));
  endtask

  // Spacing of sysEn and coreEn pulses after settling.
  task automatic measure(int eSys, int eCore, string req);
    int pS = -1, pC = -1, badS = 0, badC = 0, nS = 0, nC = 0, aS = 0, aC = 0;
    repeat (lastCore + 8 * eSys + 2 * eCore + 8) @(negedge clk);
    for (int i = 0; i < 3 * eCore + 2; i++) begin
      @(negedge clk);
      if (sysEn) begin
        if (pS >= 0 && i - pS != eSys) begin badS++; aS = i - pS; end
        pS = i; nS++;
      end
      if (coreEn) begin
        if (pC >= 0 && i - pC != eCore) begin badC++; aC = i - pC; end
        pC = i; nC++;
      end
    end
    chk(badS == 0 && nS >= 2, {req, " sys gap"}, aS, eSys);
    chk(badC == 0 && nC >= 2, {req, " core gap"}, aC, eCore);
    lastCore = eCore;
  endtask

  task automatic waitSys();
    do @(negedge clk); while (!sysEn);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int v, t0, t1, t2, cntS, cntC, badP;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk(v == 0, "R1 src", v, 0);
    rd(4'h1, v); chk(v == 0, "R1 sysdiv", v, 0);
    rd(4'h2, v); chk(v == 0, "R1 corediv", v, 0);
    rd(4'h3, v); chk(v == 15, "R1 gate", v, 15);
    rd(4'h4, v); chk(v == 0, "R1 mode", v, 0);
    rd(4'hE, v); chk(v == 0, "R1 locked", v, 0);
    chk(sysEn && coreEn, "R1 enables", int'({sysEn, coreEn}), 3);

    // R3 locked write discarded
    wr(4'h1, 8'd4);
    rd(4'h1, v); chk(v == 0, "R3 locked write", v, 0);
    measure(1, 1, "R3 ratio unchanged");

    // R4 unlock, write, relock, rejected again
    wr(4'hE, 8'h96);
    rd(4'hE, v); chk(v == 1, "R4 unlocked", v, 1);
    wr(4'h1, 8'd2);
    rd(4'h1, v); chk(v == 2, "R4 write accepted", v, 2);
    wr(4'hE, 8'h95);
    rd(4'hE, v); chk(v == 0, "R4 relocked", v, 0);
    wr(4'h1, 8'd6);
    rd(4'h1, v); chk(v == 2, "R3 write after relock", v, 2);
    measure(3, 3, "R5 locked-in ratio");
    wr(4'hE, 8'h96);

    // R2 R5 R6 vector table
    for (int k = 0; k < NVEC; k++) begin
      cfg(VEC[k][0], VEC[k][1], VEC[k][2]);
      measure(srcPer(VEC[k][0]) * VEC[k][1],
              srcPer(VEC[k][0]) * VEC[k][1] * VEC[k][2], "R2 R6 vector");
    end
    // R5 every system ratio
    for (int r = 1; r <= 32; r++) begin
      cfg(0, r, 1);
      measure(r, r, "R5 sweep");
    end
    // R6 every core ratio
    for (int r = 1; r <= 8; r++) begin
      cfg(1, 1, r);
      measure(2, 2 * r, "R6 sweep");
    end

    // R7 change ratio mid-period
    cfg(0, 8, 1);
    measure(8, 8, "R7 setup");
    waitSys(); t0 = cyc();
    wr(4'h1, 8'd1);
    waitSys(); t1 = cyc();
    waitSys(); t2 = cyc();
    chk(t1 - t0 == 8, "R7 old period completes", t1 - t0, 8);
    chk(t2 - t1 == 2, "R7 new ratio applies", t2 - t1, 2);

    // R8 gating
    cfg(0, 2, 1);
    wr(4'h3, 8'b1010);
    repeat (8) @(negedge clk);
    badP = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (periphEn != (sysEn ? 4'b1010 : 4'b0000)) badP++;
    end
    chk(badP == 0, "R8 gate pattern", badP, 0);
    wr(4'h3, 8'hFF);

    // R9 halt
    cfg(0, 1, 1);
    repeat (4) @(negedge clk);
    wr(4'h4, 8'h01);
    rd(4'h4, v); chk(v == 1 && halted, "R9 halted", v, 1);
    cntS = 0; cntC = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); cntS += int'(sysEn); cntC += int'(coreEn);
    end
    chk(cntC == 0 && cntS == 20, "R9 core stopped", cntC, 0);
    wakeup = 1'b1; @(negedge clk); wakeup = 1'b0;
    chk(!halted, "R11 halt cleared", int'(halted), 0);
    lastCore = 1;
    measure(1, 1, "R11 core resumes");

    // R10 sleep
    wr(4'h4, 8'h02);
    rd(4'h4, v); chk(v == 2 && sleeping, "R10 sleeping", v, 2);
    cntS = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); cntS += int'(sysEn) + int'(coreEn) + int'(periphEn != 0);
    end
    chk(cntS == 0, "R10 all stopped", cntS, 0);
    wakeup = 1'b1; @(negedge clk); wakeup = 1'b0;
    chk(!sleeping, "R11 sleep cleared", int'(sleeping), 0);
    measure(1, 1, "R11 clocks resume");

    // R11 wakeup beats a same-cycle mode write
    busWrEn = 1'b1; busAddr = 4'h4; busWrData = 8'h03; wakeup = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; wakeup = 1'b0;
    chk(!halted && !sleeping, "R11 wakeup priority",
        int'({sleeping, halted}), 0);

    // R2 slow select via code 3, after relock R3 still rejects mode write
    cfg(3, 1, 1);
    measure(7, 7, "R2 code 3 slow");
    wr(4'hE, 8'h00);
    wr(4'h4, 8'h01);
    chk(!halted, "R3 locked mode write", int'(halted), 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule